// File: doc/BRIEF.md
# Serial EEPROM Autoload Sequencer

After hardware reset, this block reads a 16-byte configuration image from a 3-wire serial EEPROM, one 16-bit word at a time. Each byte lands in a local 16-byte PROM buffer. Once the final word has arrived, the block copies the 48-bit station address held in the first six bytes into three 16-bit station registers. Host software reads the buffer through a small byte port. Once loading has finished, software may also overwrite the buffer. The buffer's contents never feed back into the block.

The image has a fixed layout:

| Bytes | Content |
|---|---|
| 0 to 5 | Station address |
| 6 to 11 | Reserved |
| 12, 13 | 16-bit checksum, low byte first |
| 14, 15 | Signature bytes |

The sequencer checks the checksum and the signature as the words stream in, and raises a flag when the image is valid. A busy flag covers the whole load. A done flag follows it.

Top module: `eeprom_autoload`

## Requirements
- R1: While reset is held, and at release, busy is 1 and load_done, image_ok and all of station_addr are 0; the load then begins with no host action.
- R2: Each EEPROM word transfer raises ee_cs and shifts out on ee_di a start bit 1, the read code 1 then 0, and the ADDR_W-bit word address MSB first; words 0 to 7 are read once each in ascending order.
- R3: Every transfer has exactly 3+ADDR_W+16 rising edges of ee_sk, spaced 2*CLK_DIV clock cycles apart; the 16 bits that ee_do presents after the last 16 of those rising edges form the word, MSB first.
- R4: Word w is stored little-endian: buffer byte 2w takes bits [7:0] and byte 2w+1 takes bits [15:8]; host_rdata shows the byte at host_addr in the same cycle.
- R5: station_addr bits [16i+15:16i] equal {byte 2i+1, byte 2i} for i = 0..2 after the load, and station_addr stays 0 while busy is high.
- R6: busy stays 1 until the final word is stored; in the next cycle busy is 0 and load_done is 1, and both keep those values until the next reset.
- R7: image_ok is 1 after the load exactly when the 16-bit sum of bytes 0 to 11, 14 and 15 equals {byte 13, byte 12} and bytes 14 and 15 both equal SIG_BYTE (default 57h); it changes together with load_done.
- R8: A host write (host_we high at a clock edge) is ignored while busy is 1, including at the edge that stores the final word; once busy is 0, it replaces the buffer byte at host_addr.
- R9: Host writes after the load change neither station_addr nor image_ok.
- R10: ee_sk is low whenever ee_cs is low, and between two word transfers ee_cs stays low for at least 2*CLK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_di | output | 1 | Serial command data to the EEPROM |
| ee_do | input | 1 | Serial read data from the EEPROM |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 4 | Host byte address into the PROM buffer |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Buffer byte at host_addr |
| station_addr | output | 48 | Three 16-bit station registers, register i in bits [16i+15:16i] |
| busy | output | 1 | Load in progress |
| load_done | output | 1 | Load finished |
| image_ok | output | 1 | Checksum and signature matched |

## Verification
Two things can meet in one cycle: storing the final EEPROM word, which also captures the station registers and updates busy and the check flag, and a host write to the buffer. The bench provokes this by holding a host write to one PROM byte for the whole load. It drops the strobe only on the first falling edge at which busy reads low, so the clock edge that stores the final word also carries a write attempt. The check passes when that byte still holds its EEPROM value and image_ok and the station registers match values computed arithmetically from the image. Six images are swept: valid ones, all-ones, all-zeros, a corrupted checksum and each signature byte corrupted.

// File: rtl/autoload_pkg.sv
package autoload_pkg;

   localparam int IMG_BYTES = 16;
   localparam int IMG_WORDS = IMG_BYTES / 2;
   localparam int CSUM_WORD = 6;
   localparam int SIG_WORD  = 7;
   localparam int STA_WORDS = 3;

   typedef enum logic [1:0] {
      RD_IDLE,
      RD_SHIFT,
      RD_GAP
   } rd_state_e;

   // Sum of both bytes of a 16-bit word, widened to 16 bits
   function automatic logic [15:0] pair_sum(input logic [15:0] w);
      return {8'h00, w[7:0]} + {8'h00, w[15:8]};
   endfunction

endpackage

// File: rtl/uwire_reader.sv
module uwire_reader
   import autoload_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int CLK_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ee_do,
   output logic              ee_sk,
   output logic              ee_cs,
   output logic              ee_di,
   output logic              ready,
   output logic              rd_valid,
   output logic [15:0]       rd_data
);

   localparam int CMD_LEN = 3 + ADDR_W;
   localparam int SLOTS   = CMD_LEN + 16;
   localparam int SLOT_W  = $clog2(SLOTS);

   if (CLK_DIV < 1) begin : g_bad_div
      $error("uwire_reader: CLK_DIV must be at least 1");
   end
   if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_aw
      $error("uwire_reader: ADDR_W must lie in 3..16");
   end

   rd_state_e            state;
   logic                 phase;
   logic [SLOT_W-1:0]    slot;
   logic [CMD_LEN-1:0]   cmd_sr;
   logic [15:0]          in_sr;
   logic                 tick;

   // Half-period tick: one generator variant per divider setting
   if (CLK_DIV == 1) begin : g_tick_direct
      assign tick = 1'b1;
   end else begin : g_tick_count
      localparam int DIV_W = $clog2(CLK_DIV);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             div_q <= '0;
         else if (state == RD_IDLE)              div_q <= '0;
         else if (div_q == DIV_W'(CLK_DIV - 1))  div_q <= '0;
         else                                    div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DIV_W'(CLK_DIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RD_IDLE;
         phase    <= 1'b0;
         slot     <= '0;
         cmd_sr   <= '0;
         in_sr    <= '0;
         ee_sk    <= 1'b0;
         ee_cs    <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         case (state)
            RD_IDLE: begin
               if (start) begin
                  state  <= RD_SHIFT;
                  ee_cs  <= 1'b1;
                  phase  <= 1'b0;
                  slot   <= '0;
                  cmd_sr <= {3'b110, addr};
               end
            end
            RD_SHIFT: begin
               if (tick) begin
                  if (!phase) begin
                     ee_sk <= 1'b1;
                     phase <= 1'b1;
                  end else begin
                     ee_sk  <= 1'b0;
                     phase  <= 1'b0;
                     cmd_sr <= {cmd_sr[CMD_LEN-2:0], 1'b0};
                     if (slot >= SLOT_W'(CMD_LEN)) in_sr <= {in_sr[14:0], ee_do};
                     if (slot == SLOT_W'(SLOTS - 1)) begin
                        state    <= RD_GAP;
                        ee_cs    <= 1'b0;
                        rd_valid <= 1'b1;
                        rd_data  <= {in_sr[14:0], ee_do};
                        slot     <= '0;
                     end else begin
                        slot <= slot + 1'b1;
                     end
                  end
               end
            end
            RD_GAP: begin
               if (tick) begin
                  if (!phase) phase <= 1'b1;
                  else begin
                     phase <= 1'b0;
                     state <= RD_IDLE;
                  end
               end
            end
            default: state <= RD_IDLE;
         endcase
      end
   end

   assign ee_di = cmd_sr[CMD_LEN-1];
   assign ready = (state == RD_IDLE);

   assert_sk_low_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ee_cs |-> !ee_sk);
   assert_word_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   assert_start_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> ee_cs);

endmodule

// File: rtl/prom_image_check.sv
module prom_image_check
   import autoload_pkg::*;
#(
   parameter logic [7:0] SIG_BYTE = 8'h57,
   parameter int         IDX_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             w_valid,
   input  logic [IDX_W-1:0] w_idx,
   input  logic [15:0]      w_data,
   output logic             image_ok
);

   if ((1 << IDX_W) < IMG_WORDS) begin : g_bad_idx
      $error("prom_image_check: IDX_W too narrow for the image");
   end

   logic [15:0] acc_q;
   logic [15:0] csum_q;
   logic        last_w;

   assign last_w = w_valid && (w_idx == IDX_W'(SIG_WORD));

   // Running sum over every byte except the stored checksum pair
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         csum_q   <= '0;
         image_ok <= 1'b0;
      end else if (w_valid) begin
         if (w_idx == IDX_W'(CSUM_WORD)) begin
            csum_q <= w_data;
         end else if (last_w) begin
            image_ok <= ((acc_q + pair_sum(w_data)) == csum_q) &&
                        (w_data[7:0] == SIG_BYTE) && (w_data[15:8] == SIG_BYTE);
         end else begin
            acc_q <= acc_q + pair_sum(w_data);
         end
      end
   end

   assert_ok_only_on_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !last_w |=> $stable(image_ok));

endmodule

// File: rtl/eeprom_autoload.sv
module eeprom_autoload
   import autoload_pkg::*;
#(
   parameter int         ADDR_W   = 6,
   parameter int         CLK_DIV  = 2,
   parameter logic [7:0] SIG_BYTE = 8'h57
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic        ee_sk,
   output logic        ee_cs,
   output logic        ee_di,
   input  logic        ee_do,
   input  logic        host_we,
   input  logic [3:0]  host_addr,
   input  logic [7:0]  host_wdata,
   output logic [7:0]  host_rdata,
   output logic [47:0] station_addr,
   output logic        busy,
   output logic        load_done,
   output logic        image_ok
);

   localparam int BYTE_AW = $clog2(IMG_BYTES);
   localparam int IDX_W   = $clog2(IMG_WORDS);

   if (IMG_WORDS > (1 << ADDR_W)) begin : g_bad_span
      $error("eeprom_autoload: ADDR_W cannot reach every image word");
   end
   if (BYTE_AW != 4 || STA_WORDS * 16 != 48) begin : g_bad_shape
      $error("eeprom_autoload: port widths do not match the image shape");
   end

   logic             busy_q, done_q, in_flight;
   logic [IDX_W-1:0] word_idx;
   logic             rd_ready, rd_valid, rd_start, last_word;
   logic [15:0]      rd_data;
   logic [7:0]       prom [IMG_BYTES];
   logic [47:0]      station_q;

   assign rd_start  = busy_q && rd_ready && !in_flight;
   assign last_word = rd_valid && (word_idx == IDX_W'(IMG_WORDS - 1));

   uwire_reader #(.ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV)) u_reader (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (rd_start),
      .addr     (ADDR_W'(word_idx)),
      .ee_do    (ee_do),
      .ee_sk    (ee_sk),
      .ee_cs    (ee_cs),
      .ee_di    (ee_di),
      .ready    (rd_ready),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   prom_image_check #(.SIG_BYTE(SIG_BYTE), .IDX_W(IDX_W)) u_check (
      .clk      (clk),
      .rst_n    (rst_n),
      .w_valid  (rd_valid),
      .w_idx    (word_idx),
      .w_data   (rd_data),
      .image_ok (image_ok)
   );

   // Sequencing of word reads and load status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b1;
         done_q    <= 1'b0;
         in_flight <= 1'b0;
         word_idx  <= '0;
      end else begin
         if (rd_start) in_flight <= 1'b1;
         if (rd_valid) begin
            in_flight <= 1'b0;
            word_idx  <= word_idx + 1'b1;
         end
         if (last_word) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   // PROM buffer: EEPROM words little-endian, host bytes only when idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < IMG_BYTES; b++) prom[b] <= '0;
      end else begin
         for (int b = 0; b < IMG_BYTES; b++) begin
            if (rd_valid && word_idx == IDX_W'(b / 2))
               prom[b] <= (b % 2 == 1) ? rd_data[15:8] : rd_data[7:0];
            else if (!busy_q && host_we && host_addr == BYTE_AW'(b))
               prom[b] <= host_wdata;
         end
      end
   end

   // Station registers captured once, when the final word lands
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         station_q <= '0;
      end else if (last_word) begin
         for (int s = 0; s < STA_WORDS; s++)
            station_q[16*s +: 16] <= {prom[2*s+1], prom[2*s]};
      end
   end

   assign host_rdata   = prom[host_addr];
   assign station_addr = station_q;
   assign busy         = busy_q;
   assign load_done    = done_q;

   assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q != done_q);
   assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q);
   assert_station_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !last_word |=> $stable(station_q));
   assert_host_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && host_we && !rd_valid) |=> prom[$past(host_addr)] == $past(prom[host_addr]));

endmodule

// File: tb/test_eeprom_autoload.sv
`timescale 1ns/1ps
module test_eeprom_autoload;

   localparam int AW  = 6;
   localparam int DIV = 2;
   localparam int CMD = 3 + AW;
   localparam int PER = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ee_sk, ee_cs, ee_di, ee_do;
   logic        host_we;
   logic [3:0]  host_addr;
   logic [7:0]  host_wdata, host_rdata;
   logic [47:0] station_addr;
   logic        busy, load_done, image_ok;

   always #2 clk = ~clk;

   eeprom_autoload #(.ADDR_W(AW), .CLK_DIV(DIV), .SIG_BYTE(8'h57)) i_eeprom_autoload (
      .clk(clk), .rst_n(rst_n), .ee_sk(ee_sk), .ee_cs(ee_cs), .ee_di(ee_di), .ee_do(ee_do),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .station_addr(station_addr), .busy(busy),
      .load_done(load_done), .image_ok(image_ok)
   );

   logic [7:0] img [16];
   bit         exp_ok;
   int         vecs = 0, miss = 0;
   int         word_seen, model_err, gap_err, sta_err, flag_err;

   task automatic chk(input bit good, input string tag, input logic [63:0] act, input logic [63:0] exp);
      vecs++;
      if (!good) begin
         miss++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic build_img(input int k);
      logic [15:0] sum;
      for (int b = 0; b < 16; b++) img[b] = 8'(k * 37 + b * 11 + 5);
      if (k == 4) for (int b = 0; b < 16; b++) img[b] = 8'hFF;
      if (k == 5) for (int b = 0; b < 16; b++) img[b] = 8'h00;
      img[14] = 8'h57;
      img[15] = 8'h57;
      sum = 16'h0;
      for (int b = 0; b < 16; b++) if (b != 12 && b != 13) sum = sum + 16'(img[b]);
      img[12] = sum[7:0];
      img[13] = sum[15:8];
      if (k == 1) img[12] = img[12] ^ 8'h01;
      if (k == 2) img[14] = 8'h56;
      if (k == 3) img[15] = 8'h58;
      exp_ok = !(k == 1 || k == 2 || k == 3);
   endtask

   task automatic host_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   // EEPROM model: commands on ee_di, data on ee_do after each data-slot rise (R2, R3)
   initial begin : eeprom_model
      int          bitcnt;
      logic [CMD-1:0] cmdv;
      logic [15:0] cur;
      realtime     last_rise;
      ee_do = 1'b0; bitcnt = 0; cmdv = '0; cur = '0; last_rise = 0;
      forever begin
         @(posedge ee_sk or negedge ee_cs);
         if (!ee_cs) begin
            if (bitcnt != CMD + 16) model_err++;
            bitcnt = 0;
         end else begin
            if (bitcnt > 0 && ($realtime - last_rise) != realtime'(2 * DIV * PER)) model_err++;
            last_rise = $realtime;
            if (bitcnt < CMD) begin
               cmdv = {cmdv[CMD-2:0], ee_di};
               if (bitcnt == CMD - 1) begin
                  if (cmdv[CMD-1:AW] != 3'b110 || cmdv[AW-1:0] != AW'(word_seen)) model_err++;
                  if (word_seen < 8) cur = {img[2*word_seen+1], img[2*word_seen]};
                  else begin model_err++; cur = '0; end
               end
            end else begin
               ee_do = cur[15 - (bitcnt - CMD)];
               if (bitcnt == CMD + 15) word_seen++;
            end
            bitcnt++;
         end
      end
   end

   // Port monitor away from the active edge (R5, R6, R10)
   initial begin : port_monitor
      int low_run;
      low_run = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (!ee_cs && ee_sk) gap_err++;
            if (!ee_cs) low_run++;
            else begin
               if (low_run > 0 && word_seen > 0 && low_run < 2 * DIV) gap_err++;
               low_run = 0;
            end
            if (busy && station_addr != 48'h0) sta_err++;
            if (busy == load_done) flag_err++;
         end
      end
   end

   initial begin
      rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
      for (int k = 0; k < 6; k++) begin
         logic [3:0]  ham;
         logic [47:0] sta_exp;
         int          cyc;
         build_img(k);
         rst_n = 1'b0;
         repeat (3) @(negedge clk);
         chk(busy === 1'b1 && load_done === 1'b0 && image_ok === 1'b0 && station_addr === 48'h0,
             "R1 reset state", {busy, load_done, image_ok}, 3'b100);
         word_seen = 0; model_err = 0; gap_err = 0; sta_err = 0; flag_err = 0;
         rst_n = 1'b1;
         // Host write held through the whole load, released on first idle sample (R8)
         ham = (k % 2 == 1) ? 4'd3 : 4'd14;
         host_addr = ham; host_wdata = ~img[ham]; host_we = 1'b1;
         cyc = 0;
         while (busy && cyc < 4000) begin
            @(negedge clk);
            cyc++;
         end
         host_we = 1'b0;
         chk(cyc < 4000, "R6 watchdog: load never finished", cyc, 4000);
         chk(busy === 1'b0 && load_done === 1'b1, "R6 end flags", {busy, load_done}, 2'b01);
         chk(flag_err == 0, "R6 busy/done overlap", flag_err, 0);
         chk(word_seen == 8, "R2 words read", word_seen, 8);
         chk(model_err == 0, "R2/R3 serial protocol errors", model_err, 0);
         chk(gap_err == 0, "R10 chip-select gap errors", gap_err, 0);
         chk(sta_err == 0, "R5 station written early", sta_err, 0);
         host_addr = ham; #1;
         chk(host_rdata == img[ham], "R8 write during busy ignored", host_rdata, img[ham]);
         for (int b = 0; b < 16; b++) begin
            host_addr = 4'(b); #1;
            chk(host_rdata == img[b], "R4 buffer byte", host_rdata, img[b]);
         end
         sta_exp = {img[5], img[4], img[3], img[2], img[1], img[0]};
         chk(station_addr == sta_exp, "R5 station registers", station_addr, sta_exp);
         chk(image_ok == exp_ok, "R7 image check", image_ok, exp_ok);
         repeat (5) @(negedge clk);
         chk(busy === 1'b0 && load_done === 1'b1, "R6 flags hold", {busy, load_done}, 2'b01);
         // Post-load host writes (R8, R9)
         host_write(4'd0, ~img[0]);
         host_write(4'd12, img[12] + 8'd1);
         host_addr = 4'd0; #1;
         chk(host_rdata == ~img[0], "R8 write after load", host_rdata, ~img[0]);
         host_addr = 4'd12; #1;
         chk(host_rdata == img[12] + 8'd1, "R8 write after load", host_rdata, img[12] + 8'd1);
         chk(station_addr == sta_exp, "R9 station unaffected by host", station_addr, sta_exp);
         chk(image_ok == exp_ok, "R9 image_ok unaffected by host", image_ok, exp_ok);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

endmodule